// File: doc/BRIEF.md
# Step-Down Regulator Fault Supervisor

This block supervises one step-down regulator channel. It watches a channel enable and a set of synchronous fault flags: output undervoltage, output overvoltage, over-temperature with a separate "cooled down" indication, supply undervoltage lockout and power-on reset. From these it decides whether the switching stage may run. It drives permission signals for the low-side and high-side gate drivers, an output-discharge enable, a signal that clears the error-amplifier reference to ground, and a one-cycle soft-start request that starts an external ramp toward the preset output voltage.

Output undervoltage and overvoltage faults stop the channel and start a restart timer counted in clock cycles. When the timer expires the channel starts again with a soft-start request, provided enable is still high. A thermal fault stops the channel until the cooled indication arrives. Each fault that leads to a restart uses up one restart allowance. Once the allowance is spent, the next fault latches the channel off. The latch is cleared by dropping enable or by power-on reset. An overvoltage fault keeps the low-side switch on to clamp the output. Every other stop condition turns both switches off.

Top module: `buck_fault_supervisor`

## Requirements
- R1: While `por_flag` is high the outputs show the safe pattern on the next cycle: both gate enables 0, `discharge_en` 1, `ref_clear` 1. The restart count and any latch are cleared. After release the channel passes through idle and runs on the following cycle if enable is high.
- R2: While `supply_low` is high the outputs show the safe pattern. After it falls, one idle cycle follows, then a run with soft-start if enable is high. No cooled indication is needed.
- R3: After reset, and one cycle after `enable` is seen low, the outputs show the safe pattern. Dropping enable clears the restart count and the fault latch.
- R4: An undervoltage flag seen while running gives the safe pattern on the next cycle.
- R5: An overvoltage flag seen while running gives the clamp pattern on the next cycle: `low_gate_en` 1, `high_gate_en` 0, `discharge_en` 1, `ref_clear` 1. The clamp pattern holds through the restart wait.
- R6: After an undervoltage or overvoltage fault the channel stays stopped for exactly RESTART_CYCLES cycles. It then runs, with `softstart_req` high for that first run cycle.
- R7: A thermal fault while running gives the safe pattern. The channel stays stopped, with no timeout, until `cool_flag` is seen high. It then runs with soft-start.
- R8: RESTART_LIMIT faults restart automatically. The next fault latches the safe pattern (the clamp pattern if that fault is overvoltage) until enable falls or power-on reset.
- R9: Simultaneous conditions are ranked power-on reset, supply lockout, enable low, thermal, overvoltage, undervoltage.
- R10: While running, both gate enables are 1 and `discharge_en` and `ref_clear` are 0. `softstart_req` is high only in the first run cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel on request |
| uv_flag | input | 1 | Output undervoltage detected |
| ov_flag | input | 1 | Output overvoltage detected |
| ot_flag | input | 1 | Over-temperature detected |
| cool_flag | input | 1 | Die has cooled enough to restart |
| supply_low | input | 1 | Supply below lockout threshold |
| por_flag | input | 1 | Power-on reset active |
| low_gate_en | output | 1 | Low-side driver permitted / forced on |
| high_gate_en | output | 1 | High-side driver permitted |
| discharge_en | output | 1 | Output discharge switch on |
| ref_clear | output | 1 | Reference target held at ground |
| softstart_req | output | 1 | One-cycle request to start the output ramp |

## Verification
The bench builds the block with RESTART_CYCLES set to 12 instead of a multi-millisecond count. This makes the exact timer boundary, repeated fault-restart chains and the latch after the fourth restart all reachable within a few hundred cycles. RESTART_LIMIT keeps its default of 4, so the latching threshold is exercised at its real value. With the short timeout, random fault bursts also hit the timer-expiry cycle, the cooled wait and lockout release many times over.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_POR       = 3'd0,
        ST_LOCK      = 3'd1,
        ST_IDLE      = 3'd2,
        ST_RUN       = 3'd3,
        ST_WAIT_TMR  = 3'd4,
        ST_WAIT_COOL = 3'd5,
        ST_LATCH     = 3'd6
    } sup_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UV   = 2'd1,
        FLT_OV   = 2'd2,
        FLT_OT   = 2'd3
    } run_fault_e;

    typedef struct packed {
        logic low_gate;
        logic high_gate;
        logic discharge;
        logic ref_clr;
    } drive_t;

endpackage

// File: rtl/rfs_restart_timer.sv
module rfs_restart_timer #(
    parameter int CYCLES = 700000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LAST = W'(CYCLES - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/rfs_fault_select.sv
module rfs_fault_select
    import rfs_pkg::*;
(
    input  logic       uv,
    input  logic       ov,
    input  logic       ot,
    output run_fault_e code
);
    always_comb begin
        if (ot)      code = FLT_OT;
        else if (ov) code = FLT_OV;
        else if (uv) code = FLT_UV;
        else         code = FLT_NONE;
    end
endmodule

// File: rtl/rfs_drive_decode.sv
module rfs_drive_decode
    import rfs_pkg::*;
(
    input  sup_state_e state,
    input  logic       ov_kind,
    output drive_t     drv
);
    always_comb begin
        drv = '{low_gate: 1'b0, high_gate: 1'b0, discharge: 1'b1, ref_clr: 1'b1};
        if (state == ST_RUN) begin
            drv = '{low_gate: 1'b1, high_gate: 1'b1, discharge: 1'b0, ref_clr: 1'b0};
        end else if (ov_kind && (state == ST_WAIT_TMR || state == ST_LATCH)) begin
            drv.low_gate = 1'b1;
        end
    end
endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
    import rfs_pkg::*;
#(
    parameter int RESTART_CYCLES = 700000,
    parameter int RESTART_LIMIT  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic uv_flag,
    input  logic ov_flag,
    input  logic ot_flag,
    input  logic cool_flag,
    input  logic supply_low,
    input  logic por_flag,
    output logic low_gate_en,
    output logic high_gate_en,
    output logic discharge_en,
    output logic ref_clear,
    output logic softstart_req
);
    localparam int RW = $clog2(RESTART_LIMIT + 1);
    localparam logic [RW-1:0] LIMIT = RW'(RESTART_LIMIT);

    typedef struct packed {
        sup_state_e    state;
        logic [RW-1:0] restarts;
        logic          ov_kind;
        logic          ss;
    } sup_regs_t;

    sup_regs_t  r_d, r_q;
    run_fault_e fcode;
    logic       tmr_done;
    drive_t     drv;

    rfs_fault_select u_sel (
        .uv   (uv_flag),
        .ov   (ov_flag),
        .ot   (ot_flag),
        .code (fcode)
    );

    rfs_restart_timer #(.CYCLES(RESTART_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.state == ST_WAIT_TMR),
        .done  (tmr_done)
    );

    rfs_drive_decode u_dec (
        .state   (r_q.state),
        .ov_kind (r_q.ov_kind),
        .drv     (drv)
    );

    always_comb begin
        r_d    = r_q;
        r_d.ss = 1'b0;
        if (por_flag) begin
            r_d.state    = ST_POR;
            r_d.restarts = '0;
            r_d.ov_kind  = 1'b0;
        end else if (supply_low) begin
            r_d.state = ST_LOCK;
        end else if (!enable) begin
            r_d.state    = ST_IDLE;
            r_d.restarts = '0;
            r_d.ov_kind  = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_POR, ST_LOCK: r_d.state = ST_IDLE;
                ST_IDLE: begin
                    r_d.state = ST_RUN;
                    r_d.ss    = 1'b1;
                end
                ST_RUN: begin
                    if (fcode != FLT_NONE) begin
                        r_d.ov_kind = (fcode == FLT_OV);
                        if (r_q.restarts == LIMIT) begin
                            r_d.state = ST_LATCH;
                        end else begin
                            r_d.restarts = r_q.restarts + 1'b1;
                            r_d.state    = (fcode == FLT_OT) ? ST_WAIT_COOL : ST_WAIT_TMR;
                        end
                    end
                end
                ST_WAIT_TMR: begin
                    if (tmr_done) begin
                        r_d.state = ST_RUN;
                        r_d.ss    = 1'b1;
                    end
                end
                ST_WAIT_COOL: begin
                    if (cool_flag) begin
                        r_d.state = ST_RUN;
                        r_d.ss    = 1'b1;
                    end
                end
                default: r_d.state = r_q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, restarts: '0, ov_kind: 1'b0, ss: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign low_gate_en   = drv.low_gate;
    assign high_gate_en  = drv.high_gate;
    assign discharge_en  = drv.discharge;
    assign ref_clear     = drv.ref_clr;
    assign softstart_req = r_q.ss;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic uv_flag,
    input logic ov_flag,
    input logic ot_flag,
    input logic supply_low,
    input logic por_flag,
    input logic low_gate_en,
    input logic high_gate_en,
    input logic discharge_en,
    input logic ref_clear,
    input logic softstart_req
);
    AST_POR_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        por_flag |=> (!low_gate_en && !high_gate_en && discharge_en && ref_clear)); // R1

    AST_LOCKOUT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> (!low_gate_en && !high_gate_en && discharge_en && ref_clear)); // R2

    AST_ENABLE_LOW_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!high_gate_en && discharge_en && ref_clear)); // R3

    AST_UV_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (high_gate_en && uv_flag && !ov_flag && !ot_flag && enable && !supply_low && !por_flag)
        |=> (!low_gate_en && !high_gate_en && discharge_en && ref_clear)); // R4

    AST_OV_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (high_gate_en && ov_flag && !ot_flag && enable && !supply_low && !por_flag)
        |=> (low_gate_en && !high_gate_en && discharge_en && ref_clear)); // R5

    AST_HIGH_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        high_gate_en |-> (low_gate_en && !discharge_en && !ref_clear)); // R10

    AST_SS_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        softstart_req |-> high_gate_en); // R10

    AST_SS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        softstart_req |=> !softstart_req); // R10
endmodule

bind buck_fault_supervisor rfs_checker u_chk (.*);

// File: tb/buck_fault_supervisor_test.sv
module buck_fault_supervisor_test;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 12;
    localparam int LIM = 4;
    localparam logic [4:0] SAFE   = 5'b00110;
    localparam logic [4:0] CLAMP  = 5'b10110;
    localparam logic [4:0] RUNSS  = 5'b11001;
    localparam logic [4:0] RUNNING = 5'b11000;

    logic clk = 0, rst_n = 0;
    logic enable = 0, uv_flag = 0, ov_flag = 0, ot_flag = 0, cool_flag = 0;
    logic supply_low = 0, por_flag = 0;
    logic low_gate_en, high_gate_en, discharge_en, ref_clear, softstart_req;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    buck_fault_supervisor #(.RESTART_CYCLES(TMO), .RESTART_LIMIT(LIM)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] outs();
        return {low_gate_en, high_gate_en, discharge_en, ref_clear, softstart_req};
    endfunction

    task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bench model: 0 por 1 lock 2 idle 3 run 4 wait-timer 5 wait-cool 6 latched
    int m_st = 2, m_rs = 0, m_cnt = 0;
    bit m_ov = 0, m_ss = 0;

    task automatic model_step();
        int st = m_st, rs = m_rs, cnt = m_cnt;
        bit ov = m_ov, ss = 0;
        if (por_flag) begin st = 0; rs = 0; ov = 0; end
        else if (supply_low) st = 1;
        else if (!enable) begin st = 2; rs = 0; ov = 0; end
        else case (m_st)
            0, 1: st = 2;
            2: begin st = 3; ss = 1; end
            3: if (ot_flag || ov_flag || uv_flag) begin
                   ov = !ot_flag && ov_flag;
                   if (m_rs == LIM) st = 6;
                   else begin rs = m_rs + 1; st = ot_flag ? 5 : 4; end
               end
            4: if (m_cnt == TMO - 1) begin st = 3; ss = 1; end
            5: if (cool_flag) begin st = 3; ss = 1; end
            default: ;
        endcase
        cnt = (m_st == 4) ? m_cnt + 1 : 0;
        m_st = st; m_rs = rs; m_ov = ov; m_ss = ss; m_cnt = cnt;
    endtask

    function automatic logic [4:0] model_outs();
        if (m_st == 3) return {4'b1100, m_ss};
        if (m_ov && (m_st == 4 || m_st == 6)) return CLAMP;
        return SAFE;
    endfunction

    task automatic uv_cycle();
        uv_flag = 1; step(1); chk("R4 uv stop", outs(), SAFE);
        uv_flag = 0; step(TMO - 1); chk("R6 still waiting", outs(), SAFE);
        step(1); chk("R6 timed restart", outs(), RUNSS);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        step(3); rst_n = 1; step(1);
        chk("R3 reset idle", outs(), SAFE);

        enable = 1; step(1); chk("R10 first run cycle", outs(), RUNSS);
        step(1); chk("R10 steady run", outs(), RUNNING);

        uv_cycle();                                          // restart 1

        ov_flag = 1; step(1); chk("R5 clamp", outs(), CLAMP);
        ov_flag = 0; step(TMO - 1); chk("R5 clamp held", outs(), CLAMP);
        step(1); chk("R6 restart after ov", outs(), RUNSS);  // restart 2

        ot_flag = 1; step(1); chk("R7 thermal stop", outs(), SAFE);
        ot_flag = 0; step(20); chk("R7 waits for cool", outs(), SAFE);
        cool_flag = 1; step(1); chk("R7 cooled restart", outs(), RUNSS);
        cool_flag = 0;                                       // restart 3

        uv_cycle();                                          // restart 4
        uv_flag = 1; step(1); chk("R8 latched", outs(), SAFE);
        uv_flag = 0; step(30); chk("R8 stays latched", outs(), SAFE);

        enable = 0; step(1); chk("R3 enable low", outs(), SAFE);
        enable = 1; step(1); chk("R3 latch cleared", outs(), RUNSS);
        uv_cycle();                                          // count restarted: 1

        ov_flag = 1; uv_flag = 1; step(1); chk("R9 ov over uv", outs(), CLAMP);
        ov_flag = 0; uv_flag = 0; step(TMO); chk("R9 restart", outs(), RUNSS);
        ot_flag = 1; ov_flag = 1; step(1); chk("R9 thermal over ov", outs(), SAFE);
        ot_flag = 0; ov_flag = 0; step(TMO + 2); chk("R9 no timer for thermal", outs(), SAFE);
        cool_flag = 1; step(1); chk("R7 restart", outs(), RUNSS);
        cool_flag = 0;

        supply_low = 1; ot_flag = 1; step(1); chk("R9 lockout over thermal", outs(), SAFE);
        ot_flag = 0; step(3); chk("R2 lockout held", outs(), SAFE);
        supply_low = 0; step(1); chk("R2 idle after lockout", outs(), SAFE);
        step(1); chk("R2 run after lockout", outs(), RUNSS);

        por_flag = 1; supply_low = 1; step(1); chk("R1 por safe", outs(), SAFE);
        supply_low = 0; step(2); chk("R1 por held", outs(), SAFE);
        por_flag = 0; step(1); chk("R1 idle after por", outs(), SAFE);
        step(1); chk("R1 run after por", outs(), RUNSS);
        uv_cycle();
        uv_cycle();                                          // would latch if R1 did not clear

        // constrained random phase against the bench model
        rst_n = 0; enable = 1; uv_flag = 0; ov_flag = 0; ot_flag = 0;
        cool_flag = 0; supply_low = 0; por_flag = 0;
        m_st = 2; m_rs = 0; m_cnt = 0; m_ov = 0; m_ss = 0;
        step(2); rst_n = 1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 150 == 0) enable = ~enable;
            por_flag   = ($urandom % 300 == 0);
            supply_low = ($urandom % 120 == 0);
            uv_flag    = ($urandom % 30 == 0);
            ov_flag    = ($urandom % 50 == 0);
            ot_flag    = ($urandom % 70 == 0);
            cool_flag  = ($urandom % 8 == 0);
            @(posedge clk); model_step();
            @(negedge clk); chk("R10 random vs model", outs(), model_outs());
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule